// File: doc/BRIEF.md
# Edge-and-Level Interrupt Pending Controller

This block sits beside a simple processor core and decides when one of two asynchronous interrupt sources is delivered. One source is a timer that counts down and fires on an edge. Its rising edge is latched into a pending flag that stays set until the core accepts the interrupt. The other source is an external line that is sensed by level: it counts only while the line is high, and nothing remembers it once the line drops.

Delivery is gated by a private copy of the external-interrupt-enable bit of the machine state register. The core loads this copy by pulsing a strobe whenever it writes that register. A write is therefore also the point where pending sources are looked at again. When the block offers an interrupt, the core accepts it by raising `take_i` for one cycle while `req_o` is high. Acceptance clears the enable copy, which models the automatic masking on interrupt entry. It also clears the timer flag if the timer was the source accepted.

Top module: `irq_pending_ctrl`

## Requirements
- R1: A rising edge on the synchronized timer input sets the timer pending flag. The flag is shown on `pend_o` bit 1 (value 2) and stays set until the timer interrupt is taken.
- R2: Timer edges that arrive while the flag is already set merge into it, so they give exactly one delivery.
- R3: `pend_o` bit 0 (value 1) follows the synchronized external level. A high pulse that starts and ends while the enable copy is clear is never delivered.
- R4: `req_o` stays low while the enable copy is clear. The enable copy changes only on a `msr_wr_i` strobe, which loads `ie_bit_i`, or on a take. A change of `ie_bit_i` without the strobe has no effect.
- R5: When a strobe writes 1 while a source is eligible, `req_o` is high in the cycle that follows the strobe's clock edge.
- R6: `code_o` reads 2'b01 for the external source, 2'b10 for the timer and 2'b00 when nothing is requested. When both sources are eligible, the external source wins.
- R7: A take (`req_o` and `take_i` high at a clock edge) clears the enable copy, so `req_o` is low in the next cycle. A take of the timer clears its flag, unless a new timer edge is detected in the same cycle.
- R8: Each source input passes through two flops. An external rise shows on `pend_o` after two clock edges, and a timer rise sets the flag after three.
- R9: While `rst_n` is low at a clock edge, the synchronizers, the edge history, the timer flag and the enable copy are cleared, so `req_o` is low and `code_o` and `pend_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tmr_src_i | input | 1 | Asynchronous timer source, edge sensed |
| ext_src_i | input | 1 | Asynchronous external source, level sensed |
| ie_bit_i | input | 1 | Enable bit value being written to the machine state register |
| msr_wr_i | input | 1 | One-cycle strobe for each machine state register write |
| take_i | input | 1 | Core accepts the offered interrupt |
| req_o | output | 1 | An interrupt is offered |
| code_o | output | 2 | Source being offered: 01 external, 10 timer, 00 none |
| pend_o | output | 2 | Bit 0 synchronized external level, bit 1 timer pending flag |

## Verification
The assertions take it for granted that the core raises `take_i` only in a cycle where `req_o` is high and holds it for one cycle. Without that, a take could clear the enable copy with no delivery. The bench raises `take_i` only after it has seen `req_o` high at the preceding falling edge, and drops it one edge later. Every other input changes on falling edges only. Timer pulses are spaced far enough apart for the two-flop synchronizer to see both their rise and their fall.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared source indices, vector type and delivery codes for the
// interrupt pending controller. Bit positions are behavioural: the
// arbiter gives the lowest index priority, so external sits at bit 0.
package irq_pkg;
    localparam int NSRC    = 2;
    localparam int EXT_BIT = 0;
    localparam int TMR_BIT = 1;

    typedef logic [NSRC-1:0] src_vec_t;

    localparam src_vec_t CODE_NONE = 2'b00;
    localparam src_vec_t CODE_EXT  = 2'b01;
    localparam src_vec_t CODE_TMR  = 2'b10;
endpackage

// File: rtl/irq_sync.sv
// Module irq_sync
// Multi-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a slow control level (no bus coherence is needed).
// Reset is synchronous and active low and clears every stage.
module irq_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_latch.sv
// Module irq_edge_latch
// Detects a rising edge on an already synchronized level and holds a
// sticky pending flag until it is cleared. Further edges merge into
// the set flag. If an edge and a clear coincide, the edge wins, because
// it belongs to a new event.
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic clr_i,
    output logic rise_o,
    output logic pend_o
);
    logic hist_q;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~hist_q;

    // Sticky pending flag: set on an edge, cleared on a take.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_o <= 1'b0;
        else if (rise_o) pend_o <= 1'b1;
        else if (clr_i)  pend_o <= 1'b0;
    end
endmodule

// File: rtl/irq_arbiter.sv
// Module irq_arbiter
// Fixed-priority selector: the lowest set index among the eligible
// sources wins. Purely combinational. Assumes src_i already reflects
// the pending state and that en_i masks every source.
module irq_arbiter
    import irq_pkg::*;
(
    input  logic     en_i,
    input  src_vec_t src_i,
    output logic     req_o,
    output src_vec_t code_o
);
    // Pick the lowest eligible index as a one-hot code.
    always_comb begin
        logic found;
        found  = 1'b0;
        code_o = CODE_NONE;
        for (int i = 0; i < NSRC; i++) begin
            if (en_i && src_i[i] && !found) begin
                code_o[i] = 1'b1;
                found     = 1'b1;
            end
        end
        req_o = found;
    end
endmodule

// File: rtl/irq_pending_ctrl.sv
// Module irq_pending_ctrl
// Tracks an edge-latched timer source and a level-sensed external
// source and offers one of them to the core when the local enable copy
// allows it. Assumes take_i is raised only while req_o is high.
// Acceptance clears the enable copy.
module irq_pending_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tmr_src_i,
    input  logic       ext_src_i,
    input  logic       ie_bit_i,
    input  logic       msr_wr_i,
    input  logic       take_i,
    output logic       req_o,
    output logic [1:0] code_o,
    output logic [1:0] pend_o
);
    src_vec_t raw_src;
    src_vec_t sync_src;
    src_vec_t elig_src;
    src_vec_t sel_code;
    logic     ie_q;
    logic     take_hit;
    logic     tmr_clr;
    logic     tmr_rise;
    logic     tmr_pend;

    // Gather the asynchronous inputs into one vector.
    always_comb begin
        raw_src          = '0;
        raw_src[EXT_BIT] = ext_src_i;
        raw_src[TMR_BIT] = tmr_src_i;
    end

    irq_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (NSRC)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_src),
        .dout  (sync_src)
    );

    irq_edge_latch i_tmr_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_src[TMR_BIT]),
        .clr_i  (tmr_clr),
        .rise_o (tmr_rise),
        .pend_o (tmr_pend)
    );

    // Build the eligibility vector: level for external, flag for timer.
    always_comb begin
        elig_src          = '0;
        elig_src[EXT_BIT] = sync_src[EXT_BIT];
        elig_src[TMR_BIT] = tmr_pend;
    end

    irq_arbiter i_arb (
        .en_i   (ie_q),
        .src_i  (elig_src),
        .req_o  (req_o),
        .code_o (sel_code)
    );

    assign take_hit = req_o & take_i;
    assign tmr_clr  = take_hit & sel_code[TMR_BIT];

    // Local enable copy: a take masks it, a register write reloads it.
    always_ff @(posedge clk) begin
        if (!rst_n)        ie_q <= 1'b0;
        else if (take_hit) ie_q <= 1'b0;
        else if (msr_wr_i) ie_q <= ie_bit_i;
    end

    assign code_o = sel_code;
    assign pend_o = elig_src;
endmodule

// File: rtl/irq_pending_chk.sv
// Module irq_pending_chk
// Property checker for irq_pending_ctrl, attached with bind. Assumes
// take_i is raised only while req_o is high.
module irq_pending_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_o,
    input logic       take_i,
    input logic       msr_wr_i,
    input logic [1:0] code_o,
    input logic [1:0] pend_o,
    input logic       ie_q,
    input logic       tmr_rise
);
    // R1: the timer flag persists until the timer is taken
    p_pend_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[1] && !(req_o && take_i && code_o[1])) |=> pend_o[1]);

    // R4: a clear enable copy blocks every request
    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !req_o);

    // R4: the enable copy moves only on a strobe or a take
    p_ie_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr_wr_i && !(req_o && take_i)) |=> (ie_q == $past(ie_q)));

    // R6: at most one source code at a time
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(code_o));

    // R6: external wins whenever it is eligible and a request is made
    p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && pend_o[0]) |-> (code_o == 2'b01));

    // R7: a take masks the next cycle
    p_take_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && take_i) |=> !req_o);

    // R7: taking the timer clears its flag when no new edge coincides
    p_take_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && take_i && code_o[1] && !tmr_rise) |=> !pend_o[1]);
endmodule

bind irq_pending_ctrl irq_pending_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_o    (req_o),
    .take_i   (take_i),
    .msr_wr_i (msr_wr_i),
    .code_o   (code_o),
    .pend_o   (pend_o),
    .ie_q     (ie_q),
    .tmr_rise (tmr_rise)
);

// File: tb/test_irq_pending_ctrl.sv
`timescale 1ns/1ps
module test_irq_pending_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tmr_src_i;
    logic       ext_src_i;
    logic       ie_bit_i;
    logic       msr_wr_i;
    logic       take_i;
    logic       req_o;
    logic [1:0] code_o;
    logic [1:0] pend_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_pending_ctrl i_irq_pending_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_src_i (tmr_src_i),
        .ext_src_i (ext_src_i),
        .ie_bit_i  (ie_bit_i),
        .msr_wr_i  (msr_wr_i),
        .take_i    (take_i),
        .req_o     (req_o),
        .code_o    (code_o),
        .pend_o    (pend_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ie(input logic v);
        ie_bit_i = v;
        msr_wr_i = 1'b1;
        tick(1);
        msr_wr_i = 1'b0;
    endtask

    task automatic take_once();
        take_i = 1'b1;
        tick(1);
        take_i = 1'b0;
    endtask

    task automatic tmr_pulse();
        tmr_src_i = 1'b1;
        tick(2);
        tmr_src_i = 1'b0;
        tick(2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tmr_src_i = 1'b0; ext_src_i = 1'b1;
        ie_bit_i = 1'b1; msr_wr_i = 1'b1; take_i = 1'b0;
        tick(3);
        chk("R9 req_o in reset", int'(req_o), 0);
        chk("R9 code_o in reset", int'(code_o), 0);
        chk("R9 pend_o in reset", int'(pend_o), 0);
        msr_wr_i = 1'b0; ext_src_i = 1'b0;
        rst_n = 1'b1;
        tick(3);
        chk("R9 req_o after reset", int'(req_o), 0);
    endtask

    task automatic t_latency();
        set_ie(1'b0);
        ext_src_i = 1'b1;
        tick(1);
        chk("R8 external after one edge", int'(pend_o[0]), 0);
        tick(1);
        chk("R8 external after two edges", int'(pend_o[0]), 1);
        ext_src_i = 1'b0;
        tick(3);
        tmr_src_i = 1'b1;
        tick(2);
        chk("R8 timer after two edges", int'(pend_o[1]), 0);
        tick(1);
        chk("R8 timer after three edges", int'(pend_o[1]), 1);
        tmr_src_i = 1'b0;
        tick(3);
        set_ie(1'b1);
        chk("R6 timer code", int'(code_o), 2);
        take_once();
        chk("R7 timer flag cleared by take", int'(pend_o[1]), 0);
        chk("R7 masked after take", int'(req_o), 0);
    endtask

    task automatic t_ext_level();
        set_ie(1'b1);
        ext_src_i = 1'b1;
        tick(3);
        chk("R3 external request", int'(req_o), 1);
        chk("R6 external code", int'(code_o), 1);
        ext_src_i = 1'b0;
        tick(3);
        chk("R3 request follows level low", int'(req_o), 0);
        ext_src_i = 1'b1;
        tick(3);
        take_once();
        chk("R7 masked after external take", int'(req_o), 0);
        ext_src_i = 1'b0;
        tick(3);
    endtask

    task automatic t_masked_pulse();
        set_ie(1'b0);
        ext_src_i = 1'b1;
        tick(3);
        chk("R4 no request while masked", int'(req_o), 0);
        ext_src_i = 1'b0;
        tick(3);
        set_ie(1'b1);
        chk("R3 masked pulse lost", int'(req_o), 0);
        chk("R3 nothing pending", int'(pend_o), 0);
    endtask

    task automatic t_ie_no_strobe();
        set_ie(1'b0);
        ext_src_i = 1'b1;
        tick(3);
        ie_bit_i = 1'b1;
        tick(3);
        chk("R4 enable ignored without strobe", int'(req_o), 0);
        msr_wr_i = 1'b1;
        tick(1);
        msr_wr_i = 1'b0;
        chk("R5 request right after strobe", int'(req_o), 1);
        take_once();
        ext_src_i = 1'b0;
        tick(3);
    endtask

    task automatic t_coalesce();
        set_ie(1'b0);
        tmr_pulse();
        tmr_pulse();
        tmr_pulse();
        tick(2);
        chk("R1 timer pending while masked", int'(pend_o), 2);
        tick(4);
        chk("R1 timer flag holds", int'(pend_o[1]), 1);
        set_ie(1'b1);
        chk("R5 timer request after strobe", int'(req_o), 1);
        take_once();
        set_ie(1'b1);
        tick(2);
        chk("R2 merged edges deliver once", int'(req_o), 0);
    endtask

    task automatic t_priority();
        set_ie(1'b0);
        ext_src_i = 1'b1;
        tmr_pulse();
        tick(2);
        chk("R6 both pending", int'(pend_o), 3);
        set_ie(1'b1);
        chk("R6 external wins", int'(code_o), 1);
        take_once();
        chk("R7 timer kept after external take", int'(pend_o[1]), 1);
        ext_src_i = 1'b0;
        tick(3);
        set_ie(1'b1);
        chk("R6 timer follows", int'(code_o), 2);
        take_once();
        chk("R7 idle after both taken", int'(pend_o), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        t_latency();
        t_ext_level();
        t_masked_pulse();
        t_ie_no_strobe();
        t_coalesce();
        t_priority();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule